// File: doc/BRIEF.md
# Bus Address Map Register File

This block translates addresses issued by devices on an 18-bit peripheral bus into 22-bit physical memory addresses. The bus address space is cut into 8 KB pages. The upper bus address bits pick one of 32 map entries, and the entry, plus the byte offset within the page, gives the physical address. The topmost bus page is special: it always lands in the fixed I/O region at the top of physical space, whatever its map entry holds.

The CPU loads and inspects the entries through a small register port. Each 22-bit entry occupies four bytes of register space, seen as a pair of 16-bit registers. The lower register holds entry bits 15:0, and bit 0 always reads as zero. The upper register holds entry bits 21:16 in its six low bits. Both 16-bit and 8-bit writes are accepted. A DMA engine drives the translation port one address at a time. The result is registered and stays readable until the next request.

Top module: `map_regfile`

## Requirements
- R1: The entry index of a register access is reg_addr[6:2]. reg_addr[1] selects the register of the pair: 0 is the lower register, 1 is the upper register. reg_rdata presents the read value on the cycle after reg_rd_en and holds it otherwise. An access to one entry leaves every other entry unchanged.
- R2: A read of the lower register returns entry bits 15:1, with bit 0 always 0.
- R3: A read of the upper register returns entry bits 21:16 in reg_rdata[5:0], with reg_rdata[15:6] equal to 0.
- R4: A byte write (reg_byte=1) puts reg_wdata[7:0] into entry byte reg_addr[1:0] (byte 0 is bits 7:0). A word write (reg_byte=0) puts reg_wdata[15:0] into entry bits 15:0 when reg_addr[1]=0, or into bits 31:16 when reg_addr[1]=1.
- R5: After every write the stored entry is cut to 22 bits and bit 0 is cleared. As a result, a byte write to byte 3 has no visible effect.
- R6: For a translation, xl_bus_addr[17:13] selects the entry. xl_phys_addr becomes (entry + xl_bus_addr[12:0]) mod 2^22, one cycle after xl_valid.
- R7: When xl_bus_addr[17:13] is 31, xl_phys_addr becomes 22'h3FE000 + offset, and entry 31 is ignored.
- R8: xl_done is high for exactly the cycle after each request. Between requests, xl_phys_addr keeps the last translated address.
- R9: Synchronous reset clears all entries, reg_rdata, xl_phys_addr and xl_done to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_addr | input | 7 | Register byte address within the map window |
| reg_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| reg_rdata | output | 16 | Registered read data |
| xl_valid | input | 1 | Translation request |
| xl_bus_addr | input | 18 | Device bus address to translate |
| xl_phys_addr | output | 22 | Last translated physical address |
| xl_done | output | 1 | Pulses the cycle after a request |

## Verification
The bench reads back each entry through both registers after word and byte writes. A design that lets bit 0 through, or leaks bits above 21 into the upper register, returns a wrong read value. A write to byte 3 must change nothing; a design that widens the entry shows the written bits. The bench loads an entry near the top of physical space, so that adding the offset carries past bit 21. A design that does not wrap the sum, or that adds at the wrong alignment, gives a wrong physical address. The bench translates through page 31 while entry 31 holds a nonzero value. This catches a design that reads the top page from the map. It also checks that the result holds and xl_done drops across idle cycles, and that a second reset wipes a loaded entry.

// File: rtl/map_regfile_pkg.sv
package map_regfile_pkg;
  localparam int unsigned REG_DW  = 16;
  localparam int unsigned IMG_W   = 2 * REG_DW;
  localparam int unsigned LANES   = IMG_W / 8;

  typedef enum logic { HALF_LOW = 1'b0, HALF_HIGH = 1'b1 } half_e;
endpackage

// File: rtl/map_wr_merge.sv
module map_wr_merge
  import map_regfile_pkg::*;
#(
  parameter int unsigned PHYS_AW = 22
) (
  input  logic [PHYS_AW-1:0] old_entry,
  input  logic               is_byte,
  input  logic [1:0]         lane_sel,
  input  logic [REG_DW-1:0]  wdata,
  output logic [PHYS_AW-1:0] new_entry
);
  logic [IMG_W-1:0] img;
  logic [PHYS_AW-1:0] keep_mask;

  assign keep_mask = {{(PHYS_AW-1){1'b1}}, 1'b0};

  always_comb begin
    img = IMG_W'(old_entry);
    for (int b = 0; b < LANES; b++) begin
      if (is_byte) begin
        if (lane_sel == 2'(b)) img[8*b +: 8] = wdata[7:0];
      end else begin
        if (lane_sel[1] == 1'(b / 2)) img[8*b +: 8] = wdata[8*(b % 2) +: 8];
      end
    end
    new_entry = img[PHYS_AW-1:0] & keep_mask;
  end
endmodule

// File: rtl/map_rd_fmt.sv
module map_rd_fmt
  import map_regfile_pkg::*;
#(
  parameter int unsigned PHYS_AW = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               half_sel,
  input  logic [PHYS_AW-1:0] entry,
  output logic [REG_DW-1:0]  rdata
);
  localparam int unsigned HI_W = PHYS_AW - REG_DW;

  logic [REG_DW-1:0] fmt;

  always_comb begin
    if (half_e'(half_sel) == HALF_HIGH) fmt = REG_DW'(entry[PHYS_AW-1 -: HI_W]);
    else                                fmt = {entry[REG_DW-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= fmt;
  end
endmodule

// File: rtl/map_xlate.sv
module map_xlate #(
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned PG_W    = 5,
  parameter logic [PHYS_AW-1:0] IO_BASE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [PG_W-1:0]    page,
  input  logic [OFF_W-1:0]   offset,
  input  logic [PHYS_AW-1:0] entry,
  output logic [PHYS_AW-1:0] phys,
  output logic               done
);
  localparam logic [PG_W-1:0] LAST_PG = '1;

  logic [PHYS_AW-1:0] base;
  logic [PHYS_AW-1:0] sum;

  assign base = (page == LAST_PG) ? IO_BASE : entry;
  assign sum  = base + PHYS_AW'(offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      phys <= '0;
      done <= 1'b0;
    end else begin
      done <= req;
      if (req) phys <= sum;
    end
  end
endmodule

// File: rtl/map_regfile.sv
module map_regfile
  import map_regfile_pkg::*;
#(
  parameter int unsigned BUS_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic                        reg_byte,
  input  logic [BUS_AW-OFF_W+1:0]     reg_addr,
  input  logic [15:0]                 reg_wdata,
  output logic [15:0]                 reg_rdata,
  input  logic                        xl_valid,
  input  logic [BUS_AW-1:0]           xl_bus_addr,
  output logic [PHYS_AW-1:0]          xl_phys_addr,
  output logic                        xl_done
);
  localparam int unsigned PG_W      = BUS_AW - OFF_W;
  localparam int unsigned NUM_PAGES = 1 << PG_W;
  localparam logic [PHYS_AW-1:0] IO_BASE = {{(PHYS_AW-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [PHYS_AW-1:0] map_q [NUM_PAGES];
  logic [PG_W-1:0]    reg_page;
  logic [PG_W-1:0]    xl_page;
  logic [PHYS_AW-1:0] merged;

  assign reg_page = reg_addr[PG_W+1:2];
  assign xl_page  = xl_bus_addr[BUS_AW-1:OFF_W];

  map_wr_merge #(.PHYS_AW(PHYS_AW)) u_merge (
    .old_entry (map_q[reg_page]),
    .is_byte   (reg_byte),
    .lane_sel  (reg_addr[1:0]),
    .wdata     (reg_wdata),
    .new_entry (merged)
  );

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        map_q[g] <= '0;
      else if (reg_wr_en && reg_page == PG_W'(g))
        map_q[g] <= merged;
    end
  end

  map_rd_fmt #(.PHYS_AW(PHYS_AW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (reg_rd_en),
    .half_sel (reg_addr[1]),
    .entry    (map_q[reg_page]),
    .rdata    (reg_rdata)
  );

  map_xlate #(
    .PHYS_AW (PHYS_AW),
    .OFF_W   (OFF_W),
    .PG_W    (PG_W),
    .IO_BASE (IO_BASE)
  ) u_xl (
    .clk    (clk),
    .rst    (rst),
    .req    (xl_valid),
    .page   (xl_page),
    .offset (xl_bus_addr[OFF_W-1:0]),
    .entry  (map_q[xl_page]),
    .phys   (xl_phys_addr),
    .done   (xl_done)
  );
endmodule

// File: rtl/map_regfile_chk.sv
module map_regfile_chk #(
  parameter int unsigned BUS_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_rd_en,
  input logic [BUS_AW-OFF_W+1:0] reg_addr,
  input logic [15:0]             reg_rdata,
  input logic                    xl_valid,
  input logic [BUS_AW-1:0]       xl_bus_addr,
  input logic [PHYS_AW-1:0]      xl_phys_addr,
  input logic                    xl_done
);
  localparam logic [PHYS_AW-1:0] IO_BASE = {{(PHYS_AW-OFF_W){1'b1}}, {OFF_W{1'b0}}};
  localparam logic [BUS_AW-OFF_W-1:0] LAST_PG = '1;

  p_low_bit0_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en && !reg_addr[1] |=> reg_rdata[0] == 1'b0);

  p_high_zext_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en && reg_addr[1] |=> (reg_rdata >> (PHYS_AW - 16)) == 16'd0);

  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(reg_rdata));

  p_last_page_r7: assert property (@(posedge clk) disable iff (rst)
    xl_valid && xl_bus_addr[BUS_AW-1:OFF_W] == LAST_PG |=>
      xl_phys_addr == IO_BASE + PHYS_AW'($past(xl_bus_addr[OFF_W-1:0])));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> xl_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |=> !xl_done);

  p_phys_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |=> $stable(xl_phys_addr));
endmodule

bind map_regfile map_regfile_chk #(
  .BUS_AW  (BUS_AW),
  .PHYS_AW (PHYS_AW),
  .OFF_W   (OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_rd_en    (reg_rd_en),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .xl_valid     (xl_valid),
  .xl_bus_addr  (xl_bus_addr),
  .xl_phys_addr (xl_phys_addr),
  .xl_done      (xl_done)
);

// File: tb/map_regfile_tb.sv
module map_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en, reg_rd_en, reg_byte;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        xl_valid;
  logic [17:0] xl_bus_addr;
  logic [21:0] xl_phys_addr;
  logic        xl_done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  map_regfile dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_valid(xl_valid), .xl_bus_addr(xl_bus_addr),
    .xl_phys_addr(xl_phys_addr), .xl_done(xl_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_wr_en = 0; reg_rd_en = 0; reg_byte = 0;
    reg_addr = '0; reg_wdata = '0; xl_valid = 0; xl_bus_addr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; reg_byte = b;
    @(negedge clk);
    reg_wr_en = 0; reg_byte = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  task automatic xl(input logic [17:0] ba, output logic [21:0] pa, output logic dn);
    @(negedge clk);
    xl_valid = 1; xl_bus_addr = ba;
    @(negedge clk);
    xl_valid = 0;
    pa = xl_phys_addr; dn = xl_done;
  endtask

  task automatic t_reset_state();
    logic [15:0] d; logic [21:0] pa; logic dn;
    chk("R9 phys after reset", 32'(xl_phys_addr), 32'h0);
    chk("R9 done after reset", 32'(xl_done), 32'h0);
    rd(7'd0, d); chk("R9 entry0 low", 32'(d), 32'h0);
    rd(7'd2, d); chk("R9 entry0 high", 32'(d), 32'h0);
    xl(18'h00123, pa, dn); chk("R9 cleared entry translate", 32'(pa), 32'h123);
  endtask

  task automatic t_word_rw();
    logic [15:0] d;
    wr(7'd12, 16'hABCD, 1'b0);
    wr(7'd14, 16'hFFFF, 1'b0);
    rd(7'd12, d); chk("R2 low read bit0 cleared", 32'(d), 32'hABCC);
    rd(7'd14, d); chk("R3 high read 6 bits", 32'(d), 32'h003F);
    rd(7'd16, d); chk("R1 neighbour entry untouched", 32'(d), 32'h0);
    rd(7'd8, d);  chk("R1 lower neighbour untouched", 32'(d), 32'h0);
  endtask

  task automatic t_byte_rw();
    logic [15:0] d;
    wr(7'd20, 16'h7755, 1'b1);
    wr(7'd21, 16'h33AA, 1'b1);
    wr(7'd22, 16'h9912, 1'b1);
    wr(7'd23, 16'h00FF, 1'b1);
    rd(7'd20, d); chk("R4 byte lanes 0/1 low read", 32'(d), 32'hAA54);
    rd(7'd22, d); chk("R5 byte3 no effect high read", 32'(d), 32'h0012);
    wr(7'd22, 16'hFF00, 1'b0);
    rd(7'd20, d); chk("R4 high word write keeps low", 32'(d), 32'hAA54);
    rd(7'd22, d); chk("R5 high word masked", 32'(d), 32'h0000);
  endtask

  task automatic t_translate();
    logic [21:0] pa; logic dn;
    xl(18'h06010, pa, dn);
    chk("R6 page3 translate", 32'(pa), 32'h3FABDC);
    chk("R8 done pulse", 32'(dn), 32'h1);
    wr(7'd28, 16'hFFFE, 1'b0);
    wr(7'd30, 16'h003F, 1'b0);
    xl(18'h0E004, pa, dn);
    chk("R6 sum wraps at 22 bits", 32'(pa), 32'h000002);
  endtask

  task automatic t_last_page();
    logic [21:0] pa; logic dn;
    wr(7'd124, 16'h1234, 1'b0);
    wr(7'd126, 16'h0011, 1'b0);
    xl(18'h3FABC, pa, dn);
    chk("R7 last page fixed base", 32'(pa), 32'h3FFABC);
    repeat (3) @(negedge clk);
    chk("R8 phys holds when idle", 32'(xl_phys_addr), 32'h3FFABC);
    chk("R8 done low when idle", 32'(xl_done), 32'h0);
  endtask

  task automatic t_reset_again();
    logic [15:0] d;
    do_reset();
    rd(7'd12, d); chk("R9 reset wipes loaded entry", 32'(d), 32'h0);
    chk("R9 phys cleared by reset", 32'(xl_phys_addr), 32'h0);
  endtask

  initial begin
    rst = 1'b1;
    do_reset();
    t_reset_state();
    t_word_rw();
    t_byte_rw();
    t_translate();
    t_last_page();
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule